// File: doc/BRIEF.md
# Inclusive Coherence Snoop Filter

This block is a presence directory kept beside an inclusive shared cache level. For every line held in any private cache it stores a tag and a sharer vector with one bit per core. When a core issues a coherence request, the filter looks up the line and returns the set of other cores that must be probed. A core that does not appear in the vector is never probed. This removes broadcast probes to every private cache.

The filter is conservative. A fill from a core sets that core's bit. An explicit eviction notice clears it. Lines dropped silently by a private cache keep their bit, so they are still reported as possible sharers. Over-reporting costs only extra probe traffic. Under-reporting is never allowed. Because the level is inclusive, a directory entry can only be reused after every marked sharer has been told to drop the line. When a fill finds its set full, the filter picks a victim round-robin, sends one back-invalidate for it and then installs the new line.

The control is a two-state machine. `S_IDLE` accepts requests and updates. The transition `IDLE_TO_BINV` is taken on a fill that misses in a full set. `S_BINV` drives the back-invalidate for one cycle and writes the new entry. The transition `BINV_TO_IDLE` is always taken after that single cycle.

Top module: `snoop_filter`

## Requirements
- R1: After reset, `busy`, `rsp_valid` and `binv_valid` are 0, and no line is tracked: any lookup misses.
- R2: A fill (`upd_evict`=0) from core i sets presence bit i of the line, allocating an entry if needed. All byte addresses within one 64-byte line (address bits [5:0]) map to the same entry.
- R3: A request accepted while `busy`=0 yields `rsp_valid`=1 in the next cycle. On a hit, `rsp_probe_mask` is the line's presence vector with the requester's own bit cleared (mask bit k means core k).
- R4: A request for an untracked line gives `rsp_hit`=0 and an all-zero probe mask.
- R5: An eviction notice (`upd_evict`=1) from core i clears bit i of a tracked line. When no bit remains, the entry is freed and later lookups miss.
- R6: An eviction notice for a line that is not tracked changes nothing.
- R7: A fill that misses while its set (address bits [13:6]) still has a free way takes that way. No back-invalidate is sent and `busy` stays 0.
- R8: A fill that misses in a full set causes one cycle with `busy`=1 and `binv_valid`=1 in the following cycle. During that cycle, `binv_addr` is the victim's line address (offset bits zero) and `binv_mask` is the victim's presence vector. After that cycle the new line is tracked with only the filler's bit set, and the victim is gone.
- R9: Victims in a set are chosen round-robin, starting at way 0 after reset. Free ways are taken lowest first, so successive replacements evict lines in the order they were installed.
- R10: While `busy`=1, requests and updates are ignored. No response is produced and no presence state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Coherence lookup request |
| req_addr | input | ADDR_W | Byte address of the requested line |
| req_core | input | CORE_W | Requesting core number |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Line is tracked |
| rsp_probe_mask | output | CORES | Cores to probe |
| upd_valid | input | 1 | Fill or eviction notice |
| upd_evict | input | 1 | 0 = fill, 1 = eviction notice |
| upd_addr | input | ADDR_W | Byte address of updated line |
| upd_core | input | CORE_W | Core reporting the update |
| busy | output | 1 | Replacement in progress; inputs ignored |
| binv_valid | output | 1 | Back-invalidate issued |
| binv_addr | output | ADDR_W | Line address being back-invalidated |
| binv_mask | output | CORES | Cores that must drop the victim line |

## Verification
A lookup result is registered, so the bench drives a request on a falling edge and reads `rsp_*` on the next falling edge, one rising edge later. A fill or eviction notice is written on the rising edge after it is driven, and its effect is checked through a later lookup. On a full-set fill, the back-invalidate appears in the cycle right after the fill is accepted. The bench samples `binv_*` and `busy` at that next falling edge. It drives competing inputs during that same cycle and expects no response and a return to idle one edge later.

// File: rtl/snf_pkg.sv
package snf_pkg;
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_BINV = 1'b1
    } snf_state_e;
endpackage

// File: rtl/snf_way_match.sv
module snf_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 18,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WAYS-1:0]             valid_row,
    input  logic [WAYS-1:0][TAG_W-1:0]  tag_row,
    input  logic [TAG_W-1:0]            tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way,
    output logic                        free_any,
    output logic [WAY_W-1:0]            free_way
);
    logic [WAYS-1:0] hit_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid_row[w] && (tag_row[w] == tag);
    end

    always_comb begin
        hit      = |hit_vec;
        free_any = ~&valid_row;
        hit_way  = '0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w])    hit_way  = WAY_W'(w);
            if (!valid_row[w]) free_way = WAY_W'(w);
        end
    end

    // R2: a line is never held in two ways of one set
    p_one_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/snf_victim_ptr.sv
module snf_victim_ptr #(
    parameter int SETS = 256,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAY_W-1:0] victim_way,
    input  logic             adv,
    input  logic [SET_W-1:0] adv_set
);
    logic [WAY_W-1:0] ptr [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ptr[s] <= '0;
        end else if (adv) begin
            if (ptr[adv_set] == WAY_W'(WAYS - 1)) ptr[adv_set] <= '0;
            else                                  ptr[adv_set] <= ptr[adv_set] + 1'b1;
        end
    end

    assign victim_way = ptr[rd_set];

    // R9: each replacement moves the set's pointer on
    p_ptr_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && WAYS > 1) |=> ptr[$past(adv_set)] != $past(ptr[adv_set]));
endmodule

// File: rtl/snoop_filter.sv
module snoop_filter
    import snf_pkg::*;
#(
    parameter int CORES      = 4,
    parameter int SETS       = 256,
    parameter int WAYS       = 4,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int SET_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int CORE_W = (CORES > 1) ? $clog2(CORES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CORE_W-1:0] req_core,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [CORES-1:0]  rsp_probe_mask,
    input  logic              upd_valid,
    input  logic              upd_evict,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [CORE_W-1:0] upd_core,
    output logic              busy,
    output logic              binv_valid,
    output logic [ADDR_W-1:0] binv_addr,
    output logic [CORES-1:0]  binv_mask
);
    logic [WAYS-1:0]                   vld_mem  [SETS];
    logic [WAYS-1:0][TAG_W-1:0]        tag_mem  [SETS];
    logic [WAYS-1:0][CORES-1:0]        pres_mem [SETS];

    snf_state_e state, state_nxt;

    logic [SET_W-1:0] req_set, upd_set, pend_set;
    logic [TAG_W-1:0] req_tag, upd_tag, pend_tag, vic_tag;
    logic [WAY_W-1:0] pend_way, vic_way;
    logic [CORES-1:0] pend_bit, vic_pres;
    logic             req_go, upd_go;
    logic             req_hit, req_free;
    logic [WAY_W-1:0] req_way, req_free_way;
    logic             upd_hit, upd_free;
    logic [WAY_W-1:0] upd_way, upd_free_way;
    logic [CORES-1:0] req_bit, upd_bit, req_pres, upd_pres, upd_left;
    logic             rsp_valid_q, rsp_hit_q;
    logic [CORES-1:0] rsp_mask_q;

    assign req_set = req_addr[OFF_W +: SET_W];
    assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
    assign upd_set = upd_addr[OFF_W +: SET_W];
    assign upd_tag = upd_addr[ADDR_W-1 -: TAG_W];
    assign req_go  = req_valid && (state == S_IDLE);
    assign upd_go  = upd_valid && (state == S_IDLE);
    assign req_bit = CORES'(1) << req_core;
    assign upd_bit = CORES'(1) << upd_core;

    snf_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_req_match (
        .clk(clk), .rst_n(rst_n),
        .valid_row(vld_mem[req_set]), .tag_row(tag_mem[req_set]), .tag(req_tag),
        .hit(req_hit), .hit_way(req_way), .free_any(req_free), .free_way(req_free_way)
    );

    snf_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_upd_match (
        .clk(clk), .rst_n(rst_n),
        .valid_row(vld_mem[upd_set]), .tag_row(tag_mem[upd_set]), .tag(upd_tag),
        .hit(upd_hit), .hit_way(upd_way), .free_any(upd_free), .free_way(upd_free_way)
    );

    snf_victim_ptr #(.SETS(SETS), .WAYS(WAYS)) u_victim (
        .clk(clk), .rst_n(rst_n),
        .rd_set(upd_set), .victim_way(vic_way),
        .adv(state == S_BINV), .adv_set(pend_set)
    );

    assign req_pres = pres_mem[req_set][req_way];
    assign upd_pres = pres_mem[upd_set][upd_way];
    assign upd_left = upd_pres & ~upd_bit;

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: if (upd_go && !upd_evict && !upd_hit && !upd_free) state_nxt = S_BINV; // IDLE_TO_BINV
            S_BINV: state_nxt = S_IDLE;                                                   // BINV_TO_IDLE
            default: state_nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // valid bits and lookup result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld_mem[s] <= '0;
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            rsp_mask_q  <= '0;
        end else begin
            rsp_valid_q <= req_go;
            if (req_go) begin
                rsp_hit_q  <= req_hit;
                rsp_mask_q <= req_hit ? (req_pres & ~req_bit) : '0;
            end
            if (upd_go) begin
                if (!upd_evict && !upd_hit && upd_free)
                    vld_mem[upd_set][upd_free_way] <= 1'b1;
                else if (upd_evict && upd_hit && (upd_left == '0))
                    vld_mem[upd_set][upd_way] <= 1'b0;
            end
        end
    end

    // tags, presence vectors and pending replacement
    always_ff @(posedge clk) begin
        if (upd_go && !upd_evict) begin
            if (upd_hit) begin
                pres_mem[upd_set][upd_way] <= upd_pres | upd_bit;
            end else if (upd_free) begin
                tag_mem[upd_set][upd_free_way]  <= upd_tag;
                pres_mem[upd_set][upd_free_way] <= upd_bit;
            end else begin
                pend_set <= upd_set;
                pend_tag <= upd_tag;
                pend_way <= vic_way;
                pend_bit <= upd_bit;
                vic_tag  <= tag_mem[upd_set][vic_way];
                vic_pres <= pres_mem[upd_set][vic_way];
            end
        end else if (upd_go && upd_evict && upd_hit) begin
            pres_mem[upd_set][upd_way] <= upd_left;
        end
        if (state == S_BINV) begin
            tag_mem[pend_set][pend_way]  <= pend_tag;
            pres_mem[pend_set][pend_way] <= pend_bit;
        end
    end

    // outputs
    always_comb begin
        busy           = (state == S_BINV);
        binv_valid     = (state == S_BINV);
        binv_addr      = {vic_tag, pend_set, {OFF_W{1'b0}}};
        binv_mask      = vic_pres;
        rsp_valid      = rsp_valid_q;
        rsp_hit        = rsp_hit_q;
        rsp_probe_mask = rsp_mask_q;
    end

    // R8: back-invalidate lasts exactly one cycle
    p_binv_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        binv_valid |=> !binv_valid);
    // R8: a replaced valid entry always has at least one sharer to notify
    p_binv_sharers_r8: assert property (@(posedge clk) disable iff (!rst_n)
        binv_valid |-> binv_mask != '0);
    // R3: accepted request answered next cycle
    p_rsp_timing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> rsp_valid);
    // R10: nothing answered when no request was accepted
    p_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || busy) |=> !rsp_valid);
    // R3: requester never probes itself
    p_no_self_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> (rsp_probe_mask & (CORES'(1) << $past(req_core))) == '0);
    // R4: miss never produces probes
    p_miss_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> rsp_probe_mask == '0);
endmodule

// File: tb/snoop_filter_test.sv
`timescale 1ns/1ps
module snoop_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_core = '0;
    logic        rsp_valid, rsp_hit;
    logic [3:0]  rsp_probe_mask;
    logic        upd_valid = 1'b0;
    logic        upd_evict = 1'b0;
    logic [31:0] upd_addr = '0;
    logic [1:0]  upd_core = '0;
    logic        busy, binv_valid;
    logic [31:0] binv_addr;
    logic [3:0]  binv_mask;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    snoop_filter uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_core(req_core),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_probe_mask(rsp_probe_mask),
        .upd_valid(upd_valid), .upd_evict(upd_evict), .upd_addr(upd_addr), .upd_core(upd_core),
        .busy(busy), .binv_valid(binv_valid), .binv_addr(binv_addr), .binv_mask(binv_mask)
    );

    function automatic logic [31:0] mk(input int tag, input int set, input int off);
        return (32'(tag) << 14) | (32'(set) << 6) | 32'(off);
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic upd(input logic [31:0] a, input int core, input bit ev);
        @(negedge clk);
        upd_valid = 1'b1; upd_addr = a; upd_core = 2'(core); upd_evict = ev;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic look(input logic [31:0] a, input int core, input string rq,
                        input bit exp_hit, input logic [3:0] exp_mask);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_core = 2'(core);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, {rq, " rsp_valid"}, 32'(rsp_valid), 1);
        chk(rsp_hit == exp_hit, {rq, " hit"}, 32'(rsp_hit), 32'(exp_hit));
        chk(rsp_probe_mask == exp_mask, {rq, " mask"}, 32'(rsp_probe_mask), 32'(exp_mask));
    endtask

    task automatic t_reset;
        chk(busy == 0 && binv_valid == 0 && rsp_valid == 0, "R1 outputs idle",
            {29'b0, busy, binv_valid, rsp_valid}, 0);
        look(mk(3, 7, 0), 0, "R1", 1'b0, 4'b0000);
    endtask

    task automatic t_fill_lookup;
        upd(mk(1, 2, 0), 1, 1'b0);
        look(mk(1, 2, 6'h3f), 0, "R2 same line", 1'b1, 4'b0010);
        look(mk(1, 2, 0), 1, "R3 self only", 1'b1, 4'b0000);
        upd(mk(1, 2, 4), 3, 1'b0);
        look(mk(1, 2, 0), 0, "R2 two sharers", 1'b1, 4'b1010);
        look(mk(1, 2, 0), 3, "R3 excl self", 1'b1, 4'b0010);
    endtask

    task automatic t_miss;
        look(mk(9, 2, 0), 2, "R4 miss", 1'b0, 4'b0000);
    endtask

    task automatic t_evict;
        upd(mk(1, 2, 0), 1, 1'b1);
        look(mk(1, 2, 0), 0, "R5 bit cleared", 1'b1, 4'b1000);
        upd(mk(1, 2, 0), 3, 1'b1);
        look(mk(1, 2, 0), 0, "R5 entry freed", 1'b0, 4'b0000);
    endtask

    task automatic t_evict_untracked;
        upd(mk(4, 3, 0), 2, 1'b0);
        upd(mk(5, 3, 0), 2, 1'b1);
        look(mk(4, 3, 0), 0, "R6 untracked evict", 1'b1, 4'b0100);
        look(mk(5, 3, 0), 0, "R6 still absent", 1'b0, 4'b0000);
    endtask

    task automatic t_free_ways;
        upd(mk(10, 5, 0), 1, 1'b0);
        chk(busy == 0 && binv_valid == 0, "R7 way0 no binv", {30'b0, busy, binv_valid}, 0);
        upd(mk(10, 5, 0), 3, 1'b0);
        upd(mk(11, 5, 0), 2, 1'b0);
        upd(mk(12, 5, 0), 0, 1'b0);
        upd(mk(13, 5, 0), 1, 1'b0);
        chk(busy == 0 && binv_valid == 0, "R7 way3 no binv", {30'b0, busy, binv_valid}, 0);
        look(mk(10, 5, 0), 0, "R7 line10", 1'b1, 4'b1010);
        look(mk(13, 5, 0), 0, "R7 line13", 1'b1, 4'b0010);
    endtask

    task automatic t_replace;
        @(negedge clk);
        upd_valid = 1'b1; upd_addr = mk(14, 5, 9); upd_core = 2'd0; upd_evict = 1'b0;
        @(negedge clk);
        upd_valid = 1'b0;
        chk(busy == 1 && binv_valid == 1, "R8 binv cycle", {30'b0, busy, binv_valid}, 3);
        chk(binv_addr == mk(10, 5, 0), "R8 victim addr", binv_addr, mk(10, 5, 0));
        chk(binv_mask == 4'b1010, "R8 victim mask", 32'(binv_mask), 32'hA);
        // R10: inputs offered while busy
        req_valid = 1'b1; req_addr = mk(11, 5, 0); req_core = 2'd0;
        upd_valid = 1'b1; upd_addr = mk(11, 5, 0); upd_core = 2'd2; upd_evict = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; upd_valid = 1'b0;
        chk(rsp_valid == 0, "R10 no response", 32'(rsp_valid), 0);
        chk(busy == 0 && binv_valid == 0, "R8 back to idle", {30'b0, busy, binv_valid}, 0);
        look(mk(10, 5, 0), 0, "R8 victim gone", 1'b0, 4'b0000);
        look(mk(14, 5, 0), 2, "R8 new line", 1'b1, 4'b0001);
        look(mk(11, 5, 0), 0, "R10 evict ignored", 1'b1, 4'b0100);
        @(negedge clk);
        upd_valid = 1'b1; upd_addr = mk(15, 5, 0); upd_core = 2'd3; upd_evict = 1'b0;
        @(negedge clk);
        upd_valid = 1'b0;
        chk(binv_valid == 1, "R9 second binv", 32'(binv_valid), 1);
        chk(binv_addr == mk(11, 5, 0), "R9 round robin addr", binv_addr, mk(11, 5, 0));
        chk(binv_mask == 4'b0100, "R9 round robin mask", 32'(binv_mask), 32'h4);
        @(negedge clk);
        look(mk(15, 5, 0), 0, "R9 new line", 1'b1, 4'b1000);
        look(mk(12, 5, 0), 1, "R9 survivor", 1'b1, 4'b0001);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_fill_lookup;
        t_miss;
        t_evict;
        t_evict_untracked;
        t_free_ways;
        t_replace;
        repeat (2) @(negedge clk);
        finish_run;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run;
    end
endmodule